// File: doc/BRIEF.md
# Configuration Completion Error Handler

This block stands between a host-side port that issues configuration reads and writes and the completion path of a PCI Express style link. It admits one configuration request at a time, tells the link side to send it, and then judges the completion that comes back. A clean completion passes its data through. A completion that is poisoned, fails its end-to-end CRC, or carries an Unsupported Request or Completer Abort status is turned into an all-ones response. Each of these cases also sets sticky error-status bits, and a maskable interrupt is raised from those bits.

A completion with Configuration Request Retry Status makes the block send the same request again on the next cycle. It keeps doing so until a different status comes back or a programmable retry window runs out. A retry completion that arrives after the window has run out aborts the request and sets its own detect bit. Status bits stay set until software writes ones to them.

Top module: `cfg_cpl_err_handler`

## Requirements
- R1: After reset, req_ready is 1, link_req_valid, rsp_valid and irq are 0, and every bit of unc_stat and det_stat is 0.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. link_req_valid is 1 for exactly the following cycle. req_ready stays 0 until the cycle in which the response appears, and req_valid has no effect while it is 0.
- R3: A completion with status 3'b000 (successful) and neither error flag ends the request. In the next cycle rsp_valid is 1, rsp_data equals cpl_data and rsp_abort is 0.
- R4: A completion with cpl_poison set ends the request with rsp_data all ones and rsp_abort 0, whatever its status, and sets unc_stat bit 12.
- R5: A completion with cpl_ecrc_err set ends the request with rsp_data all ones and rsp_abort 0 and sets unc_stat bit 19. If both flags are set, both bits 12 and 19 are set.
- R6: A completion with status 3'b010 (retry) and no error flag, arriving k cycles after acceptance (k ≥ 1), reissues the request when k−1 < retry_limit or when retry_limit is 0. In the next cycle link_req_valid is 1 and rsp_valid is 0. Reissues do not restart the count.
- R7: A retry completion with no error flag, retry_limit nonzero and k−1 ≥ retry_limit, ends the request with rsp_abort 1 and rsp_data all ones, and sets det_stat bit 0.
- R8: A completion with status 3'b001 (Unsupported Request), or any code other than 000, 010 and 100, with no error flag, ends the request with rsp_abort 1 and all-ones data. It sets det_stat bit 1 and unc_stat bit 20.
- R9: A completion with status 3'b100 (Completer Abort) and no error flag ends the request with rsp_abort 1 and all-ones data. It sets det_stat bits 2 and 1 and unc_stat bit 15.
- R10: Status bits are sticky. A cycle with clr_valid 1 clears exactly the bits whose clr_unc / clr_det bit is 1, and all other bits keep their value.
- R11: irq is 1 exactly when some bit of unc_stat is set with its unc_en bit set, or some bit of det_stat is set with its det_en bit set.
- R12: A completion with cpl_valid 1 while no request is outstanding (req_ready 1) is ignored. It produces no response and changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a configuration request |
| req_ready | output | 1 | No request outstanding; offer will be taken |
| link_req_valid | output | 1 | One-cycle pulse: send (or resend) the request |
| cpl_valid | input | 1 | Completion present this cycle |
| cpl_status | input | 3 | Completion status code |
| cpl_poison | input | 1 | Completion is poisoned |
| cpl_ecrc_err | input | 1 | Completion failed end-to-end CRC |
| cpl_data | input | DW | Completion payload |
| retry_limit | input | TW | Retry window in cycles, 0 disables |
| rsp_valid | output | 1 | One-cycle response to the host |
| rsp_data | output | DW | Response data |
| rsp_abort | output | 1 | Request ended without a usable completion |
| clr_valid | input | 1 | Write-one-to-clear strobe |
| clr_unc | input | 32 | Uncorrectable status bits to clear |
| clr_det | input | 3 | Detect bits to clear |
| unc_en | input | 32 | Interrupt enables for unc_stat |
| det_en | input | 3 | Interrupt enables for det_stat |
| unc_stat | output | 32 | Sticky uncorrectable status |
| det_stat | output | 3 | Sticky detect bits |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch every cycle for the relation between issue pulses and req_ready and for the sticky nature of the status bits. They also tie the poisoned, ECRC, Completer Abort and untimed retry completions to their response and status effects one cycle later, and they check that stray completions in idle produce nothing. Timeout expiry depends on a cycle count since acceptance that survives reissues, so it is shown only by the bench scenarios that place retry completions on either side of the limit. The same applies to the priority of error flags over status codes across the full code sweep, and to partial write-one-to-clear with interrupt masking.

// File: rtl/cceh_pkg.sv
package cceh_pkg;
    localparam int UNC_W = 32;
    localparam int DET_W = 3;

    localparam int UNC_POISON = 12;
    localparam int UNC_CABORT = 15;
    localparam int UNC_ECRC   = 19;
    localparam int UNC_UNSUPP = 20;

    localparam int DET_CRS_TO = 0;
    localparam int DET_NOCMPL = 1;
    localparam int DET_CABORT = 2;

    localparam logic [UNC_W-1:0] UNC_IMPL =
        (UNC_W'(1) << UNC_POISON) | (UNC_W'(1) << UNC_CABORT) |
        (UNC_W'(1) << UNC_ECRC)   | (UNC_W'(1) << UNC_UNSUPP);

    typedef enum logic [2:0] {
        CPL_SC  = 3'b000,
        CPL_UR  = 3'b001,
        CPL_CRS = 3'b010,
        CPL_CA  = 3'b100
    } cpl_st_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } phase_e;

    typedef struct packed {
        logic             done;
        logic             reissue;
        logic             abort;
        logic             ones;
        logic [UNC_W-1:0] unc_set;
        logic [DET_W-1:0] det_set;
    } cpl_act_t;

    function automatic logic [UNC_W-1:0] unc_bit(input int pos);
        return UNC_W'(1) << pos;
    endfunction

    function automatic logic [DET_W-1:0] det_bit(input int pos);
        return DET_W'(1) << pos;
    endfunction
endpackage

// File: rtl/cceh_retry_timer.sv
module cceh_retry_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    localparam logic [TW-1:0] CNT_MAX = '1;

    logic [TW-1:0] elapsed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed_q <= '0;
        end else if (start) begin
            elapsed_q <= '0;
        end else if (run && elapsed_q != CNT_MAX) begin
            elapsed_q <= elapsed_q + TW'(1);
        end
    end

    assign expired = (limit != '0) && (elapsed_q >= limit);
endmodule

// File: rtl/cceh_classify.sv
module cceh_classify
    import cceh_pkg::*;
(
    input  logic [2:0] status,
    input  logic       poison,
    input  logic       ecrc_err,
    input  logic       expired,
    output cpl_act_t   act
);
    always_comb begin
        act = '0;
        if (poison || ecrc_err) begin
            act.done = 1'b1;
            act.ones = 1'b1;
            if (poison)   act.unc_set = act.unc_set | unc_bit(UNC_POISON);
            if (ecrc_err) act.unc_set = act.unc_set | unc_bit(UNC_ECRC);
        end else begin
            case (cpl_st_e'(status))
                CPL_SC: begin
                    act.done = 1'b1;
                end
                CPL_CRS: begin
                    if (expired) begin
                        act.done    = 1'b1;
                        act.abort   = 1'b1;
                        act.ones    = 1'b1;
                        act.det_set = det_bit(DET_CRS_TO);
                    end else begin
                        act.reissue = 1'b1;
                    end
                end
                CPL_CA: begin
                    act.done    = 1'b1;
                    act.abort   = 1'b1;
                    act.ones    = 1'b1;
                    act.unc_set = unc_bit(UNC_CABORT);
                    act.det_set = det_bit(DET_CABORT) | det_bit(DET_NOCMPL);
                end
                default: begin
                    act.done    = 1'b1;
                    act.abort   = 1'b1;
                    act.ones    = 1'b1;
                    act.unc_set = unc_bit(UNC_UNSUPP);
                    act.det_set = det_bit(DET_NOCMPL);
                end
            endcase
        end
    end
endmodule

// File: rtl/cceh_err_status.sv
module cceh_err_status
    import cceh_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             log_en,
    input  logic [UNC_W-1:0] unc_set,
    input  logic [DET_W-1:0] det_set,
    input  logic             clr_valid,
    input  logic [UNC_W-1:0] clr_unc,
    input  logic [DET_W-1:0] clr_det,
    input  logic [UNC_W-1:0] unc_en,
    input  logic [DET_W-1:0] det_en,
    output logic [UNC_W-1:0] unc_stat,
    output logic [DET_W-1:0] det_stat,
    output logic             irq
);
    logic [UNC_W-1:0] unc_q, unc_keep, unc_new;
    logic [DET_W-1:0] det_q, det_keep, det_new;

    always_comb begin
        unc_keep = clr_valid ? (unc_q & ~clr_unc) : unc_q;
        det_keep = clr_valid ? (det_q & ~clr_det) : det_q;
        unc_new  = log_en ? unc_set : '0;
        det_new  = log_en ? det_set : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unc_q <= '0;
            det_q <= '0;
        end else begin
            unc_q <= (unc_keep | unc_new) & UNC_IMPL;
            det_q <= det_keep | det_new;
        end
    end

    assign unc_stat = unc_q;
    assign det_stat = det_q;
    assign irq      = (|(unc_q & unc_en)) || (|(det_q & det_en));
endmodule

// File: rtl/cfg_cpl_err_handler.sv
module cfg_cpl_err_handler
    import cceh_pkg::*;
#(
    parameter int DW = 32,
    parameter int TW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    output logic             link_req_valid,
    input  logic             cpl_valid,
    input  logic [2:0]       cpl_status,
    input  logic             cpl_poison,
    input  logic             cpl_ecrc_err,
    input  logic [DW-1:0]    cpl_data,
    input  logic [TW-1:0]    retry_limit,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_data,
    output logic             rsp_abort,
    input  logic             clr_valid,
    input  logic [UNC_W-1:0] clr_unc,
    input  logic [DET_W-1:0] clr_det,
    input  logic [UNC_W-1:0] unc_en,
    input  logic [DET_W-1:0] det_en,
    output logic [UNC_W-1:0] unc_stat,
    output logic [DET_W-1:0] det_stat,
    output logic             irq
);
    localparam logic [DW-1:0] ALL_ONES = '1;

    phase_e   phase_q;
    logic     link_q, rsp_v_q, rsp_a_q;
    logic [DW-1:0] rsp_d_q;
    logic     accept, cpl_take, expired;
    cpl_act_t act;

    assign accept   = (phase_q == PH_IDLE) && req_valid;
    assign cpl_take = (phase_q == PH_WAIT) && cpl_valid;

    cceh_retry_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .run     (phase_q == PH_WAIT),
        .limit   (retry_limit),
        .expired (expired)
    );

    cceh_classify u_class (
        .status   (cpl_status),
        .poison   (cpl_poison),
        .ecrc_err (cpl_ecrc_err),
        .expired  (expired),
        .act      (act)
    );

    cceh_err_status u_status (
        .clk       (clk),
        .rst       (rst),
        .log_en    (cpl_take),
        .unc_set   (act.unc_set),
        .det_set   (act.det_set),
        .clr_valid (clr_valid),
        .clr_unc   (clr_unc),
        .clr_det   (clr_det),
        .unc_en    (unc_en),
        .det_en    (det_en),
        .unc_stat  (unc_stat),
        .det_stat  (det_stat),
        .irq       (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            link_q  <= 1'b0;
            rsp_v_q <= 1'b0;
            rsp_a_q <= 1'b0;
            rsp_d_q <= '0;
        end else begin
            link_q  <= 1'b0;
            rsp_v_q <= 1'b0;
            if (accept) begin
                phase_q <= PH_WAIT;
                link_q  <= 1'b1;
            end
            if (cpl_take) begin
                if (act.reissue) begin
                    link_q <= 1'b1;
                end
                if (act.done) begin
                    phase_q <= PH_IDLE;
                    rsp_v_q <= 1'b1;
                    rsp_a_q <= act.abort;
                    rsp_d_q <= act.ones ? ALL_ONES : cpl_data;
                end
            end
        end
    end

    assign req_ready      = (phase_q == PH_IDLE);
    assign link_req_valid = link_q;
    assign rsp_valid      = rsp_v_q;
    assign rsp_data       = rsp_d_q;
    assign rsp_abort      = rsp_a_q;
endmodule

// File: rtl/cfg_cpl_err_handler_chk.sv
module cfg_cpl_err_handler_chk #(
    parameter int DW = 32,
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          link_req_valid,
    input logic          cpl_valid,
    input logic [2:0]    cpl_status,
    input logic          cpl_poison,
    input logic          cpl_ecrc_err,
    input logic [TW-1:0] retry_limit,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_data,
    input logic          rsp_abort,
    input logic          clr_valid,
    input logic [31:0]   unc_en,
    input logic [2:0]    det_en,
    input logic [31:0]   unc_stat,
    input logic [2:0]    det_stat,
    input logic          irq
);
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        link_req_valid |-> !req_ready); // R2
    AST_ISSUE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> link_req_valid); // R2
    AST_POISON_ONES: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && !req_ready && cpl_poison)
        |=> (rsp_valid && (&rsp_data) && !rsp_abort && unc_stat[12])); // R4
    AST_ECRC_ONES: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && !req_ready && cpl_ecrc_err)
        |=> (rsp_valid && (&rsp_data) && !rsp_abort && unc_stat[19])); // R5
    AST_CRS_REISSUE: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && !req_ready && !cpl_poison && !cpl_ecrc_err &&
         cpl_status == 3'b010 && retry_limit == '0)
        |=> (link_req_valid && !rsp_valid)); // R6
    AST_CA_LOG: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && !req_ready && !cpl_poison && !cpl_ecrc_err &&
         cpl_status == 3'b100)
        |=> (rsp_valid && rsp_abort && det_stat[2] && det_stat[1] && unc_stat[15])); // R9
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clr_valid |=> ((unc_stat & $past(unc_stat)) == $past(unc_stat) &&
                        (det_stat & $past(det_stat)) == $past(det_stat))); // R10
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (unc_en == '0 && det_en == '0) |-> !irq); // R11
    AST_IDLE_CPL: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && req_ready) |=> !rsp_valid); // R12
endmodule

bind cfg_cpl_err_handler cfg_cpl_err_handler_chk #(.DW(DW), .TW(TW)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .link_req_valid(link_req_valid), .cpl_valid(cpl_valid),
    .cpl_status(cpl_status), .cpl_poison(cpl_poison),
    .cpl_ecrc_err(cpl_ecrc_err), .retry_limit(retry_limit),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_abort(rsp_abort),
    .clr_valid(clr_valid), .unc_en(unc_en), .det_en(det_en),
    .unc_stat(unc_stat), .det_stat(det_stat), .irq(irq)
);

// File: tb/cfg_cpl_err_handler_test.sv
module cfg_cpl_err_handler_test;
    localparam int DW = 32;
    localparam int TW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, cpl_valid = 0, cpl_poison = 0, cpl_ecrc_err = 0, clr_valid = 0;
    logic [2:0] cpl_status = '0;
    logic [DW-1:0] cpl_data = '0;
    logic [TW-1:0] retry_limit = '0;
    logic [31:0] clr_unc = '0, unc_en = '0;
    logic [2:0] clr_det = '0, det_en = '0;
    logic req_ready, link_req_valid, rsp_valid, rsp_abort, irq;
    logic [DW-1:0] rsp_data;
    logic [31:0] unc_stat;
    logic [2:0] det_stat;

    int checks = 0;
    int fails = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    cfg_cpl_err_handler #(.DW(DW), .TW(TW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .link_req_valid(link_req_valid), .cpl_valid(cpl_valid),
        .cpl_status(cpl_status), .cpl_poison(cpl_poison),
        .cpl_ecrc_err(cpl_ecrc_err), .cpl_data(cpl_data),
        .retry_limit(retry_limit), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_abort(rsp_abort), .clr_valid(clr_valid), .clr_unc(clr_unc),
        .clr_det(clr_det), .unc_en(unc_en), .det_en(det_en),
        .unc_stat(unc_stat), .det_stat(det_stat), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic accept_req();
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 link pulse", 32'(link_req_valid), 32'd1);
        check("R2 ready low", 32'(req_ready), 32'd0);
    endtask

    task automatic drive_cpl(input logic [2:0] st, input logic p, input logic e,
                             input logic [31:0] d);
        cpl_valid = 1'b1; cpl_status = st; cpl_poison = p; cpl_ecrc_err = e; cpl_data = d;
        @(negedge clk);
        cpl_valid = 1'b0; cpl_poison = 1'b0; cpl_ecrc_err = 1'b0;
    endtask

    task automatic clear_all();
        clr_valid = 1'b1; clr_unc = '1; clr_det = '1;
        @(negedge clk);
        clr_valid = 1'b0; clr_unc = '0; clr_det = '0;
    endtask

    task automatic model(input logic [2:0] st, input logic p, input logic e, input bit exp_to,
                         output bit reiss, output bit abrt, output bit ones,
                         output logic [31:0] u, output logic [2:0] dt);
        reiss = 0; abrt = 0; ones = 0; u = '0; dt = '0;
        if (p || e) begin
            ones = 1;
            if (p) u[12] = 1'b1;
            if (e) u[19] = 1'b1;
        end else if (st == 3'b000) begin
        end else if (st == 3'b010) begin
            if (exp_to) begin abrt = 1; ones = 1; dt[0] = 1'b1; end
            else reiss = 1;
        end else if (st == 3'b100) begin
            abrt = 1; ones = 1; u[15] = 1'b1; dt[2] = 1'b1; dt[1] = 1'b1;
        end else begin
            abrt = 1; ones = 1; u[20] = 1'b1; dt[1] = 1'b1;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : stimulus
        bit reiss, abrt, ones;
        logic [31:0] eu;
        logic [2:0] ed;
        logic [31:0] dat;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", 32'(req_ready), 32'd1);
        check("R1 link", 32'(link_req_valid), 32'd0);
        check("R1 rsp", 32'(rsp_valid), 32'd0);
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 unc", unc_stat, 32'd0);
        check("R1 det", 32'(det_stat), 32'd0);

        // Sweep all status codes x error flags, limit disabled
        unc_en = '1; det_en = '1; retry_limit = '0;
        for (int st = 0; st < 8; st++) begin
            for (int fl = 0; fl < 4; fl++) begin
                clear_all();
                check("R10 cleared", unc_stat | 32'(det_stat), 32'd0);
                check("R11 irq off", 32'(irq), 32'd0);
                accept_req();
                dat = 32'h1357_0000 + 32'(st * 16 + fl);
                model(3'(st), fl[0], fl[1], 1'b0, reiss, abrt, ones, eu, ed);
                drive_cpl(3'(st), fl[0], fl[1], dat);
                if (reiss) begin
                    check("R6 reissue pulse", 32'(link_req_valid), 32'd1);
                    check("R6 no response", 32'(rsp_valid), 32'd0);
                    check("R6 still busy", 32'(req_ready), 32'd0);
                    drive_cpl(3'b000, 1'b0, 1'b0, dat);
                    check("R3 data after retry", rsp_data, dat);
                    check("R3 valid after retry", 32'(rsp_valid), 32'd1);
                    check("R6 no status", unc_stat | 32'(det_stat), 32'd0);
                end else begin
                    check("R3 R4 R5 R8 R9 rsp_valid", 32'(rsp_valid), 32'd1);
                    check("R3 R4 R5 R8 R9 data", rsp_data, ones ? 32'hFFFF_FFFF : dat);
                    check("R3 R4 R5 R8 R9 abort", 32'(rsp_abort), 32'(abrt));
                    check("R4 R5 R8 R9 unc", unc_stat, eu);
                    check("R8 R9 det", 32'(det_stat), 32'(ed));
                    check("R11 irq", 32'(irq), 32'((eu != 0) || (ed != 0)));
                    check("R2 ready again", 32'(req_ready), 32'd1);
                end
            end
        end

        // R6 limit zero: late retry still reissues
        clear_all();
        accept_req();
        repeat (10) @(negedge clk);
        drive_cpl(3'b010, 1'b0, 1'b0, 32'h0);
        check("R6 late retry limit0", 32'(link_req_valid), 32'd1);
        drive_cpl(3'b000, 1'b0, 1'b0, 32'hA5A5_0001);
        check("R3 data", rsp_data, 32'hA5A5_0001);

        // R6/R7 timer: limit 3, completion at k=3 reissues, k=4 aborts (no restart)
        retry_limit = 16'd3;
        clear_all();
        accept_req();
        repeat (2) @(negedge clk);
        drive_cpl(3'b010, 1'b0, 1'b0, 32'h0);
        check("R6 before limit", 32'(link_req_valid), 32'd1);
        check("R6 before limit rsp", 32'(rsp_valid), 32'd0);
        drive_cpl(3'b010, 1'b0, 1'b0, 32'h0);
        check("R7 abort after reissue", 32'(rsp_abort), 32'd1);
        check("R7 rsp valid", 32'(rsp_valid), 32'd1);
        check("R7 data ones", rsp_data, 32'hFFFF_FFFF);
        check("R7 det bit0", 32'(det_stat), 32'd1);
        check("R7 no link", 32'(link_req_valid), 32'd0);

        // R7 fresh request waiting exactly to the limit
        clear_all();
        accept_req();
        repeat (3) @(negedge clk);
        drive_cpl(3'b010, 1'b0, 1'b0, 32'h0);
        check("R7 at limit abort", 32'(rsp_abort), 32'd1);
        check("R7 at limit det", 32'(det_stat), 32'd1);
        retry_limit = '0;

        // R2 hold-off: req_valid held high while outstanding
        clear_all();
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        check("R2 first issue", 32'(link_req_valid), 32'd1);
        repeat (3) begin
            @(negedge clk);
            check("R2 held off ready", 32'(req_ready), 32'd0);
            check("R2 held off link", 32'(link_req_valid), 32'd0);
        end
        drive_cpl(3'b000, 1'b0, 1'b0, 32'h0BAD_F00D);
        check("R3 held response", rsp_data, 32'h0BAD_F00D);
        check("R2 ready at response", 32'(req_ready), 32'd1);
        req_valid = 1'b0;
        @(negedge clk);
        check("R2 no extra issue", 32'(link_req_valid), 32'd0);

        // R12 idle completion ignored
        drive_cpl(3'b100, 1'b1, 1'b1, 32'h1234_5678);
        check("R12 no rsp", 32'(rsp_valid), 32'd0);
        check("R12 no unc", unc_stat, 32'd0);
        check("R12 no det", 32'(det_stat), 32'd0);
        check("R12 still idle", 32'(req_ready), 32'd1);

        // R10 partial clear, R11 masking
        accept_req();
        drive_cpl(3'b000, 1'b1, 1'b0, 32'h0);
        accept_req();
        drive_cpl(3'b100, 1'b0, 1'b0, 32'h0);
        check("R10 accumulate", unc_stat, 32'h0000_9000);
        clr_valid = 1'b1; clr_unc = 32'h0000_1000; clr_det = 3'b100;
        @(negedge clk);
        clr_valid = 1'b0; clr_unc = '0; clr_det = '0;
        check("R10 partial unc", unc_stat, 32'h0000_8000);
        check("R10 partial det", 32'(det_stat), 32'd2);
        unc_en = '0; det_en = '0;
        #1 check("R11 masked", 32'(irq), 32'd0);
        unc_en = 32'h0008_0000;
        #1 check("R11 other bit", 32'(irq), 32'd0);
        unc_en = 32'h0000_8000;
        #1 check("R11 unc enable", 32'(irq), 32'd1);
        unc_en = '0; det_en = 3'b010;
        #1 check("R11 det enable", 32'(irq), 32'd1);

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule